// File: doc/BRIEF.md
# Quadrature Counter Serial Command Front End

This block is the serial slave port that sits in front of a quadrature counter core. An active-low chip select frames each transaction. The first byte received in a frame is an instruction: its top two bits name an operation and the next three bits name a target register. The bytes after it are data. Write data goes into two mode bytes and a preset word, which this block holds and presents to the core. Read data comes from those registers or from the core's live counter, output latch and status byte, and leaves on MISO. Clear and load instructions produce single-cycle strobes toward the core.

The serial inputs are synchronised into the system clock, which must run at least eight times faster than SCK. SPI mode 0 is used: MOSI is sampled on the rising SCK edge and MISO changes after the falling edge. Data moves most significant bit first. The counter, latch and preset words are `CNT_BYTES` bytes wide; the mode and status registers are one byte wide.

The controller is a state machine with five states. `ST_IDLE` is the state while select is high. `ST_CMD` collects the instruction byte. `ST_RD` shifts read data out. `ST_WR` gathers write data. `ST_DONE` ignores any further bytes. The transitions are:
- From `ST_IDLE` to `ST_CMD` when select falls.
- From `ST_CMD` to `ST_RD` when a read names a readable register.
- From `ST_CMD` to `ST_WR` when a write names a writable register.
- From `ST_CMD` to `ST_DONE` for every other instruction.
- From `ST_RD` or `ST_WR` to `ST_DONE` after the last data byte the register needs.
- From any state to `ST_IDLE` as soon as select rises.

Top module: `qcnt_spi_front`

## Requirements
- R1: Instruction decoding uses fixed fields. Bits 7:6 give the operation: 00 clear, 01 read, 10 write, 11 load. Bits 5:3 give the target: 001 mode byte 0, 010 mode byte 1, 011 preset, 100 live counter, 101 output latch, 110 status. Targets 000 and 111 select nothing. Bits 2:0 have no effect.
- R2: A clear zeroes mode byte 0 or mode byte 1. A clear of the counter pulses `clr_cnt_o`, and a clear of status pulses `clr_stat_o`. A clear of any other target changes no output.
- R3: A write stores data into exactly one register. For mode byte 0 and mode byte 1, the first data byte is stored. For the preset, `CNT_BYTES` data bytes are stored, most significant byte first, and the preset updates only once the last byte has arrived. A write to any other target changes no register.
- R4: A load of the preset pulses `load_cnt_o`, and a load of the output latch pulses `latch_o`. A load of any other target produces no strobe.
- R5: A read of the counter pulses `latch_o` once. It then shifts out the `cnt_i` value captured at decode, as `CNT_BYTES` bytes with the MSB first.
- R6: A read of a mode byte or of status shifts out one byte, and a read of the output latch shifts out `CNT_BYTES` bytes. A read of the preset or of no target shifts out zeros. Once the register's length has been sent, MISO stays 0.
- R7: Every strobe is one clock wide. A frame produces at most one strobe, and no two strobes are ever high together.
- R8: When select rises mid-frame, the frame is abandoned. A partly received write changes nothing, and the next frame starts its instruction from bit 0.
- R9: After reset, the mode bytes and the preset are zero, and MISO and all strobes are low.
- R10: Data bytes beyond the length a register needs have no effect.
- R11: MISO is 0 while idle, during the instruction byte and during write frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock |
| mosi_i | input | 1 | Serial data in |
| cs_ni | input | 1 | Active-low frame select |
| miso_o | output | 1 | Serial data out |
| cnt_i | input | 8*CNT_BYTES | Live counter value from the core |
| latch_i | input | 8*CNT_BYTES | Output latch value from the core |
| status_i | input | 8 | Status byte from the core |
| mode0_o | output | 8 | Mode byte 0 |
| mode1_o | output | 8 | Mode byte 1 |
| preset_o | output | 8*CNT_BYTES | Preset word |
| clr_cnt_o | output | 1 | Strobe: clear the counter |
| clr_stat_o | output | 1 | Strobe: clear status |
| load_cnt_o | output | 1 | Strobe: copy the preset into the counter |
| latch_o | output | 1 | Strobe: copy the counter into the latch |

## Verification
A wrong decode or a wrong state shows up within one frame. A misrouted operation either produces the wrong strobe count or leaves a different value on the mode or preset outputs. A bad byte count or a bad shift alignment corrupts the bytes read back on MISO at the first data bit that is affected. Sweeping every operation against every target, with the ignored bits in two patterns, makes each decode path visible at the ports in the frame that exercises it. The abort cases leave stale bit-counter state, which garbles the very next instruction.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
    typedef enum logic [1:0] {
        OP_CLR = 2'b00,
        OP_RD  = 2'b01,
        OP_WR  = 2'b10,
        OP_LD  = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        SEL_NONE_LO = 3'd0,
        SEL_MODE0   = 3'd1,
        SEL_MODE1   = 3'd2,
        SEL_PRESET  = 3'd3,
        SEL_COUNT   = 3'd4,
        SEL_LATCH   = 3'd5,
        SEL_STATUS  = 3'd6,
        SEL_NONE_HI = 3'd7
    } sel_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_CMD  = 3'd1,
        ST_RD   = 3'd2,
        ST_WR   = 3'd3,
        ST_DONE = 3'd4
    } st_e;
endpackage

// File: rtl/qspi_sync.sv
module qspi_sync #(
    parameter int           W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/qspi_shift.sv
module qspi_shift #(
    parameter int CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             frame_clr_i,
    input  logic             sck_i,
    input  logic             mosi_i,
    input  logic             ld_en_i,
    input  logic [CNT_W-1:0] ld_val_i,
    output logic [7:0]       rx_byte_o,
    output logic             byte_done_o,
    output logic             miso_o
);
    logic             sck_q;
    logic             rise;
    logic             fall;
    logic [2:0]       bit_cnt_q;
    logic [7:0]       rx_sr_q;
    logic             done_q;
    logic [CNT_W-1:0] tx_sr_q;
    logic             armed_q;

    assign rise = sck_i & ~sck_q;
    assign fall = ~sck_i & sck_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sck_q <= 1'b0;
        else         sck_q <= sck_i;
    end

    // receive side: bit counter and byte assembly
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bit_cnt_q <= '0;
            rx_sr_q   <= '0;
            done_q    <= 1'b0;
        end else if (frame_clr_i) begin
            bit_cnt_q <= '0;
            rx_sr_q   <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (rise) begin
                rx_sr_q   <= {rx_sr_q[6:0], mosi_i};
                bit_cnt_q <= bit_cnt_q + 3'd1;
                done_q    <= (bit_cnt_q == 3'd7);
            end
        end
    end

    // transmit side: shift after each falling edge that follows a sampled bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tx_sr_q <= '0;
            armed_q <= 1'b0;
        end else if (frame_clr_i) begin
            tx_sr_q <= '0;
            armed_q <= 1'b0;
        end else if (ld_en_i) begin
            tx_sr_q <= ld_val_i;
            armed_q <= 1'b0;
        end else if (rise) begin
            armed_q <= 1'b1;
        end else if (fall && armed_q) begin
            tx_sr_q <= tx_sr_q << 1;
            armed_q <= 1'b0;
        end
    end

    assign rx_byte_o   = rx_sr_q;
    assign byte_done_o = done_q;
    assign miso_o      = tx_sr_q[CNT_W-1];
endmodule

// File: rtl/qcnt_spi_front.sv
module qcnt_spi_front
    import qspi_pkg::*;
#(
    parameter int CNT_BYTES = 4
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   sck_i,
    input  logic                   mosi_i,
    input  logic                   cs_ni,
    output logic                   miso_o,
    input  logic [8*CNT_BYTES-1:0] cnt_i,
    input  logic [8*CNT_BYTES-1:0] latch_i,
    input  logic [7:0]             status_i,
    output logic [7:0]             mode0_o,
    output logic [7:0]             mode1_o,
    output logic [8*CNT_BYTES-1:0] preset_o,
    output logic                   clr_cnt_o,
    output logic                   clr_stat_o,
    output logic                   load_cnt_o,
    output logic                   latch_o
);
    localparam int CNT_W = 8 * CNT_BYTES;
    localparam int BCW   = $clog2(CNT_BYTES + 1);

    logic [2:0]       sync_s;
    logic             sck_s;
    logic             mosi_s;
    logic             cs_s;
    logic [7:0]       rx_byte;
    logic             byte_done;
    logic             rd_go;
    logic [CNT_W-1:0] ld_val;
    op_e              op;
    sel_e             sel;

    st_e              state_q;
    st_e              state_d;
    sel_e             sel_q;
    logic [BCW-1:0]   byte_cnt_q;
    logic [BCW-1:0]   len_q;
    logic [CNT_W-1:0] acc_q;
    logic [7:0]       mode0_q;
    logic [7:0]       mode1_q;
    logic [CNT_W-1:0] preset_q;
    logic             last_byte;
    logic             data_readable;
    logic             data_writable;

    qspi_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    ({cs_ni, sck_i, mosi_i}),
        .q_o    (sync_s)
    );
    assign cs_s   = sync_s[2];
    assign sck_s  = sync_s[1];
    assign mosi_s = sync_s[0];

    qspi_shift #(.CNT_W(CNT_W)) u_shift (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .frame_clr_i (cs_s),
        .sck_i       (sck_s),
        .mosi_i      (mosi_s),
        .ld_en_i     (rd_go),
        .ld_val_i    (ld_val),
        .rx_byte_o   (rx_byte),
        .byte_done_o (byte_done),
        .miso_o      (miso_o)
    );

    assign op  = op_e'(rx_byte[7:6]);
    assign sel = sel_e'(rx_byte[5:3]);

    assign data_readable = (sel == SEL_MODE0) || (sel == SEL_MODE1) || (sel == SEL_COUNT) ||
                           (sel == SEL_LATCH) || (sel == SEL_STATUS);
    assign data_writable = (sel == SEL_MODE0) || (sel == SEL_MODE1) || (sel == SEL_PRESET);
    assign last_byte     = (byte_cnt_q == len_q - BCW'(1));
    assign rd_go         = (state_q == ST_CMD) && byte_done && !cs_s && (op == OP_RD);

    // left-aligned read source, captured by the shifter at decode
    always_comb begin
        unique case (sel)
            SEL_MODE0:  ld_val = CNT_W'(mode0_q) << (CNT_W - 8);
            SEL_MODE1:  ld_val = CNT_W'(mode1_q) << (CNT_W - 8);
            SEL_COUNT:  ld_val = cnt_i;
            SEL_LATCH:  ld_val = latch_i;
            SEL_STATUS: ld_val = CNT_W'(status_i) << (CNT_W - 8);
            default:    ld_val = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (!cs_s) state_d = ST_CMD;
            ST_CMD: begin
                if (cs_s) begin
                    state_d = ST_IDLE;
                end else if (byte_done) begin
                    if (op == OP_RD && data_readable)      state_d = ST_RD;
                    else if (op == OP_WR && data_writable) state_d = ST_WR;
                    else                                   state_d = ST_DONE;
                end
            end
            ST_RD, ST_WR: begin
                if (cs_s)                        state_d = ST_IDLE;
                else if (byte_done && last_byte) state_d = ST_DONE;
            end
            ST_DONE: if (cs_s) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs, registers and strobes
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sel_q      <= SEL_NONE_LO;
            byte_cnt_q <= '0;
            len_q      <= BCW'(1);
            acc_q      <= '0;
            mode0_q    <= '0;
            mode1_q    <= '0;
            preset_q   <= '0;
            clr_cnt_o  <= 1'b0;
            clr_stat_o <= 1'b0;
            load_cnt_o <= 1'b0;
            latch_o    <= 1'b0;
        end else begin
            clr_cnt_o  <= 1'b0;
            clr_stat_o <= 1'b0;
            load_cnt_o <= 1'b0;
            latch_o    <= 1'b0;
            if (state_q == ST_CMD && byte_done && !cs_s) begin
                sel_q      <= sel;
                byte_cnt_q <= '0;
                acc_q      <= '0;
                if (sel == SEL_MODE0 || sel == SEL_MODE1 || sel == SEL_STATUS)
                    len_q <= BCW'(1);
                else
                    len_q <= BCW'(CNT_BYTES);
                unique case (op)
                    OP_CLR: begin
                        if (sel == SEL_MODE0)  mode0_q    <= '0;
                        if (sel == SEL_MODE1)  mode1_q    <= '0;
                        if (sel == SEL_COUNT)  clr_cnt_o  <= 1'b1;
                        if (sel == SEL_STATUS) clr_stat_o <= 1'b1;
                    end
                    OP_LD: begin
                        if (sel == SEL_PRESET) load_cnt_o <= 1'b1;
                        if (sel == SEL_LATCH)  latch_o    <= 1'b1;
                    end
                    OP_RD: begin
                        if (sel == SEL_COUNT) latch_o <= 1'b1;
                    end
                    default: ;
                endcase
            end
            if ((state_q == ST_RD || state_q == ST_WR) && byte_done && !cs_s) begin
                byte_cnt_q <= byte_cnt_q + BCW'(1);
                if (state_q == ST_WR) begin
                    acc_q <= (acc_q << 8) | CNT_W'(rx_byte);
                    if (last_byte) begin
                        unique case (sel_q)
                            SEL_MODE0:  mode0_q  <= rx_byte;
                            SEL_MODE1:  mode1_q  <= rx_byte;
                            SEL_PRESET: preset_q <= (acc_q << 8) | CNT_W'(rx_byte);
                            default: ;
                        endcase
                    end
                end
            end
        end
    end

    assign mode0_o  = mode0_q;
    assign mode1_o  = mode1_q;
    assign preset_o = preset_q;
endmodule

// File: rtl/qcnt_spi_front_chk.sv
module qcnt_spi_front_chk
    import qspi_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             miso_o,
    input logic [7:0]       mode0_o,
    input logic [7:0]       mode1_o,
    input logic [CNT_W-1:0] preset_o,
    input logic             clr_cnt_o,
    input logic             clr_stat_o,
    input logic             load_cnt_o,
    input logic             latch_o,
    input st_e              state_i
);
    logic any_strobe;
    assign any_strobe = clr_cnt_o | clr_stat_o | load_cnt_o | latch_o;

    AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({clr_cnt_o, clr_stat_o, load_cnt_o, latch_o})); // R7

    AST_STROBE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        any_strobe |=> !any_strobe); // R7

    AST_LATCH_AFTER_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        latch_o |-> $past(state_i) == ST_CMD); // R5

    AST_IDLE_MISO_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == ST_IDLE) |-> !miso_o); // R11

    AST_PRESET_ONLY_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(preset_o) |-> $past(state_i) == ST_WR); // R3

    AST_MODE0_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(mode0_o) |-> ($past(state_i) == ST_WR || $past(state_i) == ST_CMD)); // R2

    AST_MODE1_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(mode1_o) |-> ($past(state_i) == ST_WR || $past(state_i) == ST_CMD)); // R2
endmodule

bind qcnt_spi_front qcnt_spi_front_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .miso_o     (miso_o),
    .mode0_o    (mode0_o),
    .mode1_o    (mode1_o),
    .preset_o   (preset_o),
    .clr_cnt_o  (clr_cnt_o),
    .clr_stat_o (clr_stat_o),
    .load_cnt_o (load_cnt_o),
    .latch_o    (latch_o),
    .state_i    (state_q)
);

// File: tb/qcnt_spi_front_bench.sv
`timescale 1ns/1ps
module qcnt_spi_front_bench;
    localparam int NB = 4;
    localparam int W  = 8 * NB;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sck = 1'b0;
    logic         mosi = 1'b0;
    logic         cs_n = 1'b1;
    logic         miso;
    logic [W-1:0] m_cnt;
    logic [W-1:0] m_latch;
    logic [7:0]   stat_v = 8'h00;
    logic [7:0]   mode0;
    logic [7:0]   mode1;
    logic [W-1:0] preset;
    logic         clr_cnt;
    logic         clr_stat;
    logic         load_cnt;
    logic         latch_stb;

    logic         seed_stb = 1'b0;
    logic [W-1:0] seed_val = '0;
    int           n_clrc = 0;
    int           n_clrs = 0;
    int           n_ld   = 0;
    int           n_lat  = 0;
    int           n_multi = 0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    qcnt_spi_front #(.CNT_BYTES(NB)) u_qcnt_spi_front (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .sck_i      (sck),
        .mosi_i     (mosi),
        .cs_ni      (cs_n),
        .miso_o     (miso),
        .cnt_i      (m_cnt),
        .latch_i    (m_latch),
        .status_i   (stat_v),
        .mode0_o    (mode0),
        .mode1_o    (mode1),
        .preset_o   (preset),
        .clr_cnt_o  (clr_cnt),
        .clr_stat_o (clr_stat),
        .load_cnt_o (load_cnt),
        .latch_o    (latch_stb)
    );

    // behavioural core model and strobe counters
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt   <= '0;
            m_latch <= '0;
        end else begin
            if (seed_stb)      m_cnt <= seed_val;
            else if (clr_cnt)  m_cnt <= '0;
            else if (load_cnt) m_cnt <= preset;
            if (latch_stb) m_latch <= m_cnt;
        end
        if (clr_cnt)   n_clrc <= n_clrc + 1;
        if (clr_stat)  n_clrs <= n_clrs + 1;
        if (load_cnt)  n_ld   <= n_ld + 1;
        if (latch_stb) n_lat  <= n_lat + 1;
        if ((32'(clr_cnt) + 32'(clr_stat) + 32'(load_cnt) + 32'(latch_stb)) > 1)
            n_multi <= n_multi + 1;
    end

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (8) @(posedge clk);
        #2;
    endtask

    task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i >= 8 - nbits; i--) begin
            mosi = tx[i];
            half();
            rx[i] = miso;
            sck = 1'b1;
            half();
            sck = 1'b0;
        end
    endtask

    task automatic frame(input logic [7:0] instr, input int ndata, input logic [W-1:0] wdata,
                         output logic [W-1:0] rdata, output logic [7:0] rinstr);
        logic [7:0] rb;
        cs_n = 1'b0;
        half();
        xfer(instr, 8, rinstr);
        rdata = '0;
        for (int b = 0; b < ndata; b++) begin
            xfer(wdata[W-1-8*b -: 8], 8, rb);
            rdata = (rdata << 8) | W'(rb);
        end
        half();
        cs_n = 1'b1;
        half();
        half();
    endtask

    task automatic seed(input logic [W-1:0] v);
        seed_val = v;
        seed_stb = 1'b1;
        @(posedge clk);
        #2;
        seed_stb = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [1:0]   ops [4];
        logic [W-1:0] rdata;
        logic [7:0]   rinstr;
        logic [7:0]   e_m0;
        logic [7:0]   e_m1;
        logic [W-1:0] e_pre;
        logic [W-1:0] e_rd;
        logic [W-1:0] wdata;
        logic [W-1:0] sv;
        logic [W-1:0] lat0;
        logic [7:0]   rb;
        int d_cc, d_cs, d_ld, d_lt, k, c0, c1, c2, c3;
        ops[0] = 2'b10; ops[1] = 2'b01; ops[2] = 2'b11; ops[3] = 2'b00;

        repeat (4) @(posedge clk);
        #2;
        // R9 reset state
        chk("R9 mode0", W'(mode0), '0);
        chk("R9 mode1", W'(mode1), '0);
        chk("R9 preset", preset, '0);
        chk("R9 miso", W'(miso), '0);
        chk("R9 strobes", W'({clr_cnt, clr_stat, load_cnt, latch_stb}), '0);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        #2;

        e_m0 = '0; e_m1 = '0; e_pre = '0;
        k = 0;
        // R1 sweep: every operation, every target, two patterns in the ignored bits
        for (int oi = 0; oi < 4; oi++) begin
            for (int s = 0; s < 8; s++) begin
                for (int lp = 0; lp < 2; lp++) begin
                    logic [7:0] instr;
                    logic [1:0] op;
                    int nd;
                    op    = ops[oi];
                    instr = {op, 3'(s), (lp != 0) ? 3'b111 : 3'b010};
                    sv    = 32'hA5C3_0000 + 32'(k) * 32'h0101_1357;
                    wdata = 32'h1357_9BDF ^ (32'(k) * 32'h0F0F_1111);
                    seed(sv);
                    stat_v = 8'h80 | 8'(k);
                    lat0 = m_latch;
                    c0 = n_clrc; c1 = n_clrs; c2 = n_ld; c3 = n_lat;
                    d_cc = 0; d_cs = 0; d_ld = 0; d_lt = 0;
                    e_rd = '0;
                    nd = (op == 2'b01 || op == 2'b10) ? NB : 0;
                    unique case (op)
                        2'b00: begin
                            if (s == 1) e_m0 = '0;
                            if (s == 2) e_m1 = '0;
                            if (s == 4) d_cc = 1;
                            if (s == 6) d_cs = 1;
                        end
                        2'b10: begin
                            if (s == 1) e_m0 = wdata[W-1 -: 8];
                            if (s == 2) e_m1 = wdata[W-1 -: 8];
                            if (s == 3) e_pre = wdata;
                        end
                        2'b11: begin
                            if (s == 3) d_ld = 1;
                            if (s == 5) d_lt = 1;
                        end
                        default: begin
                            if (s == 1) e_rd = W'(e_m0) << (W - 8);
                            if (s == 2) e_rd = W'(e_m1) << (W - 8);
                            if (s == 4) begin e_rd = sv; d_lt = 1; end
                            if (s == 5) e_rd = lat0;
                            if (s == 6) e_rd = W'(stat_v) << (W - 8);
                        end
                    endcase
                    frame(instr, nd, wdata, rdata, rinstr);
                    chk("R11 miso during instruction", W'(rinstr), '0);
                    if (op == 2'b01) chk("R5/R6 read data", rdata, e_rd);
                    else             chk("R11 miso during write", rdata, '0);
                    chk("R2/R3/R10 mode0", W'(mode0), W'(e_m0));
                    chk("R2/R3/R10 mode1", W'(mode1), W'(e_m1));
                    chk("R3 preset", preset, e_pre);
                    chk("R2 clr_cnt count", W'(n_clrc - c0), W'(d_cc));
                    chk("R2 clr_stat count", W'(n_clrs - c1), W'(d_cs));
                    chk("R4 load_cnt count", W'(n_ld - c2), W'(d_ld));
                    chk("R4/R5 latch count", W'(n_lat - c3), W'(d_lt));
                    if (op == 2'b01 && s == 4) chk("R5 latch holds read value", m_latch, sv);
                    k++;
                end
            end
        end
        chk("R7 no simultaneous strobes", W'(n_multi), '0);

        // R8: abandoned preset write keeps the old preset
        e_pre = preset;
        cs_n = 1'b0;
        half();
        xfer(8'b10_011_000, 8, rb);
        xfer(8'h11, 8, rb);
        xfer(8'h22, 8, rb);
        half();
        cs_n = 1'b1;
        half(); half();
        chk("R8 aborted write", preset, e_pre);

        // R8: abandoned partial instruction, then a full write and read of mode0
        frame(8'b10_001_000, NB, 32'h5A00_0000, rdata, rinstr);
        cs_n = 1'b0;
        half();
        xfer(8'b00_001_000, 3, rb);
        half();
        cs_n = 1'b1;
        half(); half();
        chk("R8 partial clear ignored", W'(mode0), W'(8'h5A));
        frame(8'b01_001_000, NB, '0, rdata, rinstr);
        chk("R8 next frame realigned", rdata, 32'h5A00_0000);

        // R3 full preset write then load into the counter model
        frame(8'b10_011_101, NB, 32'hDEAD_BEEF, rdata, rinstr);
        chk("R3 preset word", preset, 32'hDEAD_BEEF);
        frame(8'b11_011_000, 0, '0, rdata, rinstr);
        chk("R4 load reached core", m_cnt, 32'hDEAD_BEEF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule